// File: doc/BRIEF.md
# Gated Pulse Counter with Hidden-Prescaler Recovery

The block counts rising edges on an external pulse input during a gate period. The edges first advance a narrow prescaler that has no read path. Each rollover of the prescaler advances a wider main counter, and the main counter can be read.

When the gate closes, the external input is cut off and a recovery sequencer takes over the prescaler input. It first stores a snapshot of the main counter. It then issues single internal pulses until the main counter moves away from that snapshot, and it counts down from zero, modulo the prescaler size, once for each pulse. When the main counter moves, this down-count equals the prescaler contents from before recovery. The sequencer then presents the snapshot as the upper field of the result and the recovered value as the lower field.

Because the upper field comes from the snapshot, a wrap of the main counter during recovery does not corrupt the result. If a full prescaler cycle of injected pulses never moves the main counter, the block raises a fault flag and gives no result.

Top module: `gcnt_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `busy_o`, `done_o` and `fault_o` are 0 and `result_o` is 0.
- R2: When `start_gate_i` is high while `busy_o` is low, the gate opens on that clock edge. The prescaler, the main counter and `fault_o` are cleared, and `busy_o` is 1 from the next cycle. `start_gate_i` has no effect while `busy_o` is high.
- R3: While the gate is open, each rising edge of `pulse_i` (after a two-flop synchronizer) advances the total count by exactly one. Once `stop_gate_i` has been sampled high while the gate is open, further edges on `pulse_i` have no effect on the result.
- R4: After a normal recovery, `result_o` equals the number of `pulse_i` rising edges seen while the gate was open, modulo 2^(MAIN_W+PRE_W). The upper MAIN_W bits are the main counter and the lower PRE_W bits are the recovered prescaler value. This holds for prescaler residues 0, 1, 255 and any other value.
- R5: Recovery takes 4 cycles per injected pulse. The prescaler needs k = 256 − p pulses to carry, where p is its residue, and k = 256 when p = 0. `done_o` goes high 2 + 4k clock edges after the edge that samples `stop_gate_i`, with that sampling edge counted as the first.
- R6: If the main counter wraps from all ones to zero during recovery, the upper field of `result_o` still holds the main counter value from before recovery.
- R7: If 256 injected pulses leave the main counter unchanged, `fault_o` rises 1026 edges after the stop edge, counted as in R5. `done_o` does not pulse and `busy_o` falls. `fault_o` then holds until the next accepted start.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle. `result_o` changes only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_gate_i | input | 1 | Opens a new gate period when idle |
| stop_gate_i | input | 1 | Closes the gate and starts recovery |
| pulse_i | input | 1 | External asynchronous pulse input |
| busy_o | output | 1 | Gate open or recovery running |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| fault_o | output | 1 | The main counter never carried during recovery |
| result_o | output | MAIN_W+PRE_W (24) | Main counter above the recovered prescaler value |

## Verification
The bench counts clock edges from the edge that samples `stop_gate_i`. It expects `done_o` at exactly edge 2 + 4k, with k derived from the residue of the true count, and it expects `fault_o` at edge 1026 when the carry into the main counter is forced off. Each observation is taken on a falling edge, after the registers have settled.

External pulses are fed with at least four cycles between rising edges. The gate is closed at least four cycles after the last rising edge, so that edge has left the synchronizer and been counted first. The bench sets the main counter to 4 bits, so the wrap-during-recovery case can be reached within the run. It also keeps toggling `pulse_i` during one recovery to show that those edges are not counted.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GATE, ST_SNAP, ST_HI, ST_LO, ST_WAIT, ST_CMP
  } gcnt_state_e;
endpackage

// File: rtl/gcnt_edge_sync.sv
module gcnt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/gcnt_stage.sv
module gcnt_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + ONE;
  end

  assign carry_o = inc_i & (&cnt_o);
endmodule

// File: rtl/gcnt_recover.sv
module gcnt_recover
  import gcnt_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int MAIN_W = 16,
  localparam int RES_W = MAIN_W + PRE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [MAIN_W-1:0] main_i,
  output logic              gate_open_o,
  output logic              clr_o,
  output logic              inj_step_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [RES_W-1:0]  result_o
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  gcnt_state_e       state_q;
  logic [MAIN_W-1:0] snap_q;
  logic [PRE_W-1:0]  tally_q;
  logic              inj_q, inj_prev_q;

  assign gate_open_o = (state_q == ST_GATE);
  assign clr_o       = (state_q == ST_IDLE) && start_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign inj_step_o  = inj_q & ~inj_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      snap_q     <= '0;
      tally_q    <= '0;
      inj_q      <= 1'b0;
      inj_prev_q <= 1'b0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      result_o   <= '0;
    end else begin
      done_o     <= 1'b0;
      inj_prev_q <= inj_q;
      case (state_q)
        ST_IDLE: if (start_i) begin
          fault_o <= 1'b0;
          state_q <= ST_GATE;
        end
        ST_GATE: if (stop_i) state_q <= ST_SNAP;
        ST_SNAP: begin
          snap_q  <= main_i;
          tally_q <= '0;
          state_q <= ST_HI;
        end
        ST_HI: begin
          inj_q   <= 1'b1;
          state_q <= ST_LO;
        end
        ST_LO: begin
          inj_q   <= 1'b0;
          tally_q <= tally_q - ONE;
          state_q <= ST_WAIT;
        end
        ST_WAIT: state_q <= ST_CMP;
        ST_CMP: begin
          if (main_i != snap_q) begin
            // snapshot keeps the upper field correct across a wrap
            result_o <= {snap_q, tally_q};
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (tally_q == '0) begin
            fault_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_HI;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcnt_top.sv
module gcnt_top #(
  parameter int PRE_W       = 8,
  parameter int MAIN_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = MAIN_W + PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_gate_i,
  input  logic             stop_gate_i,
  input  logic             pulse_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [RES_W-1:0] result_o
);
  logic              ext_rise, gate_open, clr, inj_step;
  logic              presc_inc, presc_carry, main_carry;
  logic [PRE_W-1:0]  presc_cnt;
  logic [MAIN_W-1:0] main_cnt;

  gcnt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pulse_i), .rise_o(ext_rise)
  );

  assign presc_inc = gate_open ? ext_rise : inj_step;

  gcnt_stage #(.W(PRE_W)) u_presc (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(presc_inc),
    .cnt_o(presc_cnt), .carry_o(presc_carry)
  );

  gcnt_stage #(.W(MAIN_W)) u_main (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(presc_carry),
    .cnt_o(main_cnt), .carry_o(main_carry)
  );

  gcnt_recover #(.PRE_W(PRE_W), .MAIN_W(MAIN_W)) u_rec (
    .clk_i, .rst_ni,
    .start_i(start_gate_i), .stop_i(stop_gate_i), .main_i(main_cnt),
    .gate_open_o(gate_open), .clr_o(clr), .inj_step_o(inj_step),
    .busy_o, .done_o, .fault_o, .result_o
  );

  logic unused_ok;
  assign unused_ok = ^{presc_cnt, main_carry};
endmodule

// File: rtl/gcnt_checker.sv
module gcnt_checker #(
  parameter int RES_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_gate_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o,
  input logic [RES_W-1:0] result_o,
  input logic             gate_open,
  input logic             inj_step
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R8
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_gate_i && !busy_o) |=> (busy_o && !fault_o)); // R2
  AST_NO_INJ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_open |-> !inj_step); // R3
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !(start_gate_i && !busy_o)) |=> fault_o); // R7
  AST_FAULT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> (!done_o && !busy_o)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && !fault_o)); // R1
endmodule

bind gcnt_top gcnt_checker #(.RES_W(RES_W)) u_chk (
  .clk_i, .rst_ni, .start_gate_i, .busy_o, .done_o, .fault_o, .result_o,
  .gate_open, .inj_step
);

// File: tb/gcnt_top_tb_top.sv
module gcnt_top_tb_top;
  localparam int PRE_W  = 8;
  localparam int MAIN_W = 4;
  localparam int RES_W  = MAIN_W + PRE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_g = 1'b0, stop_g = 1'b0, pulse = 1'b0;
  logic busy, done, fault;
  logic [RES_W-1:0] result;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gcnt_top #(.PRE_W(PRE_W), .MAIN_W(MAIN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_gate_i(start_g), .stop_gate_i(stop_g),
    .pulse_i(pulse), .busy_o(busy), .done_o(done), .fault_o(fault),
    .result_o(result)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_steps(input int cnt);
    int p = cnt % 256;
    return (p == 0) ? 256 : 256 - p;
  endfunction

  function automatic int exp_result(input int cnt);
    return cnt % (1 << RES_W);
  endfunction

  task automatic open_gate();
    @(negedge clk); start_g = 1'b1;
    @(negedge clk); start_g = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R2 fault cleared", fault, 0);
  endtask

  task automatic feed(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      pulse = 1'b1; repeat (2) @(negedge clk);
      pulse = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // returns edges counted from the stop-sampling edge
  task automatic close_and_wait(input bit toggle, output int edges,
                                output bit saw_done, output bit saw_fault);
    edges = 0; saw_done = 0; saw_fault = 0;
    stop_g = 1'b1;
    while (edges < 2000) begin
      @(posedge clk); edges++;
      @(negedge clk); stop_g = 1'b0;
      if (toggle) pulse = ~pulse;
      if (done) begin saw_done = 1; break; end
      if (fault) begin saw_fault = 1; break; end
    end
    pulse = 1'b0;
  endtask

  task automatic run(input int cnt, input bit toggle, input string tag);
    int e; bit d, f;
    open_gate();
    feed(cnt);
    close_and_wait(toggle, e, d, f);
    check({tag, " R8 done seen"}, d, 1);
    check({tag, " R4 result"}, result, exp_result(cnt));
    check({tag, " R5 latency"}, e, 2 + 4 * exp_steps(cnt));
    check({tag, " R8 busy low at done"}, busy, 0);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, done, 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", wd, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int e; bit d, f;
    int unsigned r;
    r = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 fault in reset", fault, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 result after reset", result, 0);

    run(0, 0, "residue0 empty");
    run(1, 0, "residue1");
    run(255, 0, "residue255");
    run(256, 0, "residue0 full");
    run(257, 1, "R3 ignore during recovery");
    run(511, 0, "carry path");
    run(3847, 0, "R6 wrap residue7");
    run(4095, 0, "R6 wrap residue255");
    run(3840, 0, "R6 wrap residue0");
    for (int i = 0; i < 3; i++) begin
      r = $urandom % 1000;
      run(int'(r), 0, "random");
    end

    // R7: suppress the carry into the main counter during recovery
    open_gate();
    feed(300);
    force dut_i.presc_carry = 1'b0;
    close_and_wait(0, e, d, f);
    release dut_i.presc_carry;
    check("R7 fault raised", f, 1);
    check("R7 no done on fault", d, 0);
    check("R7 fault latency", e, 1026);
    check("R7 busy low on fault", busy, 0);
    repeat (5) @(negedge clk);
    check("R7 fault held", fault, 1);
    run(42, 0, "R7 after fault");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule